// File: doc/BRIEF.md
# Nibble Nonvolatile Register with Output Latches

This block keeps a 4-bit working register that a host reads and writes over a small parallel bus with active-low chip-enable, output-enable and write-enable strobes. The register value is also driven without pause onto four dedicated output pins. These pins let the block stand in for a bank of configuration switches that holds its setting across power loss.

The block also holds a shadow copy of the register that survives a simulated power-down. When the supply-good input falls, the block copies the working register into the shadow over a fixed, parameterised number of cycles, pulses a done flag, and then drops the working register. When supply-good returns, a recall sequence of a parameterised length loads the shadow back into the working register. Only then is the output-valid flag raised. The bus is served only in the normal running state.

All strobes are sampled on the clock. A write pulse must be followed by at least one cycle with the write inactive before the next pulse starts. The data port is split into an input, an output and a drive enable, which feed a tri-state pad outside the block.

Top module: `nibble_nvram`

## Requirements
- R1: While reset is asserted and for RECALL_CYCLES clock edges after it is released, out_valid is 0 and out_pins is 0. After that time, out_valid is 1 and out_pins equals SHADOW_INIT.
- R2: A read is served in the running state when ce_n=0, oe_n=0 and we_n=1. In that case dq_oe is 1 and dq_o equals the working register. With ce_n=1 or oe_n=1, dq_oe is 0.
- R3: When we_n=0, dq_oe is 0 even if ce_n=0 and oe_n=0.
- R4: A write pulse lasts while ce_n=0 and we_n=0. It ends on the first sampled cycle where either strobe is high. The data stored is dq_i from the last cycle of the pulse, and the register takes it on the clock edge at which the end is sampled.
- R5: In the running state, out_pins always equals the working register. It changes only when a write completes.
- R6: When vcc_ok falls in the running state, the store completes STORE_CYCLES+1 edges later. At that edge the shadow takes the working register and store_done pulses high for exactly one cycle. Ordinary writes never update the shadow.
- R7: After a store, out_valid is 0 and out_pins is 0 until recall. When vcc_ok is high in the powered-down state, out_valid rises RECALL_CYCLES+1 edges later, and out_pins then equals the shadow.
- R8: While a store, power-down or recall is in progress, reads are not driven and writes have no effect. A write pulse still open when vcc_ok falls is discarded.
- R9: A supply loss during recall performs no store (store_done stays 0). The shadow keeps its earlier value.
- R10: A store that has started runs to completion even if vcc_ok returns during it. Recall then begins on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_ok | input | 1 | Supply-good indication; low means power is failing |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| dq_i | input | W | Data from the bus pad |
| dq_o | output | W | Data to the bus pad |
| dq_oe | output | 1 | Pad drive enable |
| out_pins | output | W | Continuous copy of the working register |
| out_valid | output | 1 | Outputs hold recalled or written data |
| store_done | output | 1 | One-cycle pulse when a store finishes |

## Verification
The hardest conditions to reach are a supply loss that lands inside an open write pulse, and a supply loss during recall. In both cases the only evidence is the value that the following recall brings back. The bench therefore drops vcc_ok with the write strobes still low. It also drops vcc_ok one edge into a recall, then brings power back and checks the recalled nibble against the value known to be in the shadow. It also raises vcc_ok in the middle of a store, and it runs the store-and-recall cycle once for every one of the 16 nibble values.

// File: rtl/nvn_pkg.sv
// Shared types for the nibble nonvolatile register.
// Assumes nothing beyond a single clock domain.
package nvn_pkg;
    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_RUN    = 2'd1,
        ST_STORE  = 2'd2,
        ST_DOWN   = 2'd3
    } nv_state_t;
endpackage

// File: rtl/nvn_bus.sv
// Bus front end: finds the end of a write pulse and decides when the read
// path may drive. Assumes strobes are synchronous to clk, and that pulses
// are separated by at least one inactive cycle.
module nvn_bus #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic         we_n,
    input  logic [W-1:0] dq_i,
    output logic         commit,
    output logic [W-1:0] hold_data,
    output logic         rd_en
);
    logic wr_active;
    logic wr_seen;

    // Write pulse is live only when the block is running.
    assign wr_active = run && !ce_n && !we_n;

    // Track an open pulse and keep the most recent data of that pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen   <= 1'b0;
            hold_data <= '0;
        end else if (!run) begin
            wr_seen   <= 1'b0;
        end else if (wr_active) begin
            wr_seen   <= 1'b1;
            hold_data <= dq_i;
        end else begin
            wr_seen   <= 1'b0;
        end
    end

    // Pulse ended: it was open last cycle and is closed now.
    assign commit = wr_seen && run && !wr_active;

    // Read drive; a low write enable always wins over output enable.
    assign rd_en = run && !ce_n && !oe_n && we_n;
endmodule

// File: rtl/nvn_ctrl.sv
// Power sequencer: recall after reset or power return, store on supply
// loss, and the shadow copy. Assumes vcc_ok is synchronous to clk.
module nvn_ctrl
    import nvn_pkg::*;
#(
    parameter int           W             = 4,
    parameter int           STORE_CYCLES  = 16,
    parameter int           RECALL_CYCLES = 8,
    parameter logic [W-1:0] SHADOW_INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vcc_ok,
    input  logic [W-1:0] vol,
    output nv_state_t    state,
    output logic         load_shadow,
    output logic [W-1:0] shadow,
    output logic         store_done
);
    localparam int MAXC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ST_LAST = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] RC_LAST = CW'(RECALL_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Recall is finishing this cycle.
    assign load_shadow = (state == ST_RECALL) && vcc_ok && (cnt == RC_LAST);

    // Sequencer state, step counter, shadow copy and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RECALL;
            cnt        <= '0;
            shadow     <= SHADOW_INIT;
            store_done <= 1'b0;
        end else begin
            store_done <= 1'b0;
            case (state)
                ST_RECALL: begin
                    if (!vcc_ok) begin
                        state <= ST_DOWN;
                        cnt   <= '0;
                    end else if (cnt == RC_LAST) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!vcc_ok) begin
                        state <= ST_STORE;
                        cnt   <= '0;
                    end
                end
                ST_STORE: begin
                    if (cnt == ST_LAST) begin
                        shadow     <= vol;
                        store_done <= 1'b1;
                        state      <= ST_DOWN;
                        cnt        <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (vcc_ok) begin
                        state <= ST_RECALL;
                        cnt   <= '0;
                    end
                end
            endcase
        end
    end

    // R6
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !store_done);
    // R6
    store_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_done) |-> $past(state) == ST_STORE);
    // R9
    recall_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECALL) |=> (state != ST_STORE));
    // R10
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && cnt != ST_LAST) |=> (state == ST_STORE));
endmodule

// File: rtl/nibble_nvram.sv
// Top: working register, output latches and bus data path.
// Assumes all inputs are synchronous to clk; the pad tri-state is external.
module nibble_nvram
    import nvn_pkg::*;
#(
    parameter int           W             = 4,
    parameter int           STORE_CYCLES  = 16,
    parameter int           RECALL_CYCLES = 8,
    parameter logic [W-1:0] SHADOW_INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vcc_ok,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic         we_n,
    input  logic [W-1:0] dq_i,
    output logic [W-1:0] dq_o,
    output logic         dq_oe,
    output logic [W-1:0] out_pins,
    output logic         out_valid,
    output logic         store_done
);
    nv_state_t    state;
    logic         run;
    logic         commit;
    logic         load_shadow;
    logic         rd_en;
    logic [W-1:0] hold_data;
    logic [W-1:0] shadow;
    logic [W-1:0] vol;

    assign run = (state == ST_RUN);

    nvn_bus #(.W(W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .dq_i      (dq_i),
        .commit    (commit),
        .hold_data (hold_data),
        .rd_en     (rd_en)
    );

    nvn_ctrl #(
        .W             (W),
        .STORE_CYCLES  (STORE_CYCLES),
        .RECALL_CYCLES (RECALL_CYCLES),
        .SHADOW_INIT   (SHADOW_INIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .vcc_ok      (vcc_ok),
        .vol         (vol),
        .state       (state),
        .load_shadow (load_shadow),
        .shadow      (shadow),
        .store_done  (store_done)
    );

    // Working register: recall load, loss while unpowered, or bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol <= '0;
        end else if (load_shadow) begin
            vol <= shadow;
        end else if (state == ST_DOWN || state == ST_RECALL) begin
            vol <= '0;
        end else if (commit) begin
            vol <= hold_data;
        end
    end

    // Output latches and read path.
    assign out_pins  = vol;
    assign out_valid = (state == ST_RUN) || (state == ST_STORE);
    assign dq_o      = vol;
    assign dq_oe     = rd_en;

    // R3
    we_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dq_oe);
    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!commit && !dq_oe));
    // R5
    pins_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !commit && !load_shadow) |=> $stable(out_pins));
    // R7
    valid_after_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state) == ST_RECALL);
endmodule

// File: tb/nibble_nvram_test.sv
module nibble_nvram_test;
    localparam int SC = 5;
    localparam int RC = 3;
    localparam logic [3:0] INIT = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_ok = 1'b1;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [3:0] dq_i = '0;
    logic [3:0] dq_o, out_pins;
    logic       dq_oe, out_valid, store_done;

    int checks = 0;
    int errors = 0;

    nibble_nvram #(.W(4), .STORE_CYCLES(SC), .RECALL_CYCLES(RC), .SHADOW_INIT(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .out_pins(out_pins), .out_valid(out_valid), .store_done(store_done)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr_we(input logic [3:0] v);
        ce_n = 1'b0; we_n = 1'b0; dq_i = v;
        tick();
        idle();
        tick();
    endtask

    // which: 0 waits for store_done, 1 for out_valid
    task automatic wait_for(input int which, output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            n++;
            if ((which == 0 && store_done) || (which == 1 && out_valid)) break;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        // R1 reset state and recall of the initial shadow
        tick(); tick(); tick();
        check("R1 valid in reset", out_valid, 0);
        check("R1 pins in reset", out_pins, 0);
        rst_n = 1'b1;
        wait_for(1, n);
        check("R1 recall edges", n, RC);
        check("R1 initial pins", out_pins, INIT);

        // R2 R3 R4 R5 sweep over every value
        for (int v = 0; v < 16; v++) begin
            wr_we(4'(v));
            check("R4 R5 pins after write", out_pins, v);
            ce_n = 1'b0; oe_n = 1'b0; #1;
            check("R2 read drive", dq_oe, 1);
            check("R2 read data", dq_o, v);
            we_n = 1'b0; #1;
            check("R3 we wins", dq_oe, 0);
            tick();
            idle(); #1;
            ce_n = 1'b1; oe_n = 1'b0; #1;
            check("R2 ce high no drive", dq_oe, 0);
            idle();
            tick();
            check("R3 no write from we/oe overlap end", out_pins, v);
            wr_we(4'(15 - v));
            check("R5 pins follow", out_pins, 15 - v);
        end

        // R4 data from the last pulse cycle wins
        ce_n = 1'b0; we_n = 1'b0; dq_i = 4'h3;
        tick();
        dq_i = 4'hC;
        tick();
        check("R4 no change mid pulse", out_pins, 0);
        we_n = 1'b1;
        tick();
        check("R4 last data stored", out_pins, 4'hC);
        // R4 pulse ended by ce rising
        idle(); tick();
        ce_n = 1'b0; we_n = 1'b0; dq_i = 4'h5;
        tick();
        ce_n = 1'b1;
        tick();
        check("R4 ce ended write", out_pins, 4'h5);
        idle(); tick();

        // R6 R7 R8 power cycle for every value
        for (int v = 0; v < 16; v++) begin
            wr_we(4'(v));
            vcc_ok = 1'b0;
            wait_for(0, n);
            check("R6 store edges", n, SC + 1);
            tick();
            check("R6 single pulse", store_done, 0);
            check("R7 down valid", out_valid, 0);
            check("R7 down pins", out_pins, 0);
            ce_n = 1'b0; we_n = 1'b0; dq_i = ~4'(v);
            tick();
            idle();
            tick();
            ce_n = 1'b0; oe_n = 1'b0; #1;
            check("R8 no read when down", dq_oe, 0);
            idle();
            vcc_ok = 1'b1;
            wait_for(1, n);
            check("R7 recall edges", n, RC + 1);
            check("R7 R8 recalled value", out_pins, v);
        end

        // R8 open write at supply loss is discarded
        wr_we(4'h9);
        ce_n = 1'b0; we_n = 1'b0; dq_i = 4'h6; vcc_ok = 1'b0;
        tick();
        idle();
        wait_for(0, n);
        check("R8 store after open write", n, SC);
        vcc_ok = 1'b1;
        wait_for(1, n);
        check("R8 open write dropped", out_pins, 4'h9);

        // R9 supply loss during recall stores nothing
        vcc_ok = 1'b0;
        wait_for(0, n);
        vcc_ok = 1'b1;
        tick();
        vcc_ok = 1'b0;
        wait_for(0, n);
        check("R9 no store during recall", store_done, 0);
        vcc_ok = 1'b1;
        wait_for(1, n);
        check("R9 shadow kept", out_pins, 4'h9);

        // R10 store completes though supply returns
        wr_we(4'h4);
        vcc_ok = 1'b0;
        tick();
        vcc_ok = 1'b1;
        ce_n = 1'b0; oe_n = 1'b0; #1;
        check("R8 no read during store", dq_oe, 0);
        idle();
        wait_for(0, n);
        check("R10 store edges", n, SC);
        wait_for(1, n);
        check("R10 recall follows", n, RC + 1);
        check("R10 value", out_pins, 4'h4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule